// File: doc/BRIEF.md
# Split-Read 64-bit Cycle Counter

This block is a free-running cycle counter, two words wide, that software reads one word at a time through a small register port. The low word and the high word are read with separate accesses. Between those two reads the counter keeps running, and the core may take an interrupt or an exception. A small tracker watches each low-then-high pair. It records in a status bit whether the two words belong to the same instant.

Software reads the low word, then the high word, then the control register. It repeats that sequence until the status bit comes back as 1, and then joins the two words into one value. A write of 1 to bit 0 of the control register starts counting, and a write of 0 stops it. The core raises a one-cycle pulse on `evt_taken` whenever it takes an interrupt or an exception.

Accesses are made one at a time, at most one per cycle. A read request that is sampled at a rising edge returns its word on `rd_data`, together with a one-cycle `rd_valid` pulse, in the cycle after that edge. The value returned is the state held before that edge. The port has no back-pressure: the requester must take each response in the cycle it appears. Writes produce no response.

Top module: `split_counter`

## Requirements
- R1: After reset the counter is 0, counting is disabled, the status bit is 0 and `rd_valid` is 0.
- R2: A write to the control register (offset 0x103) sets the enable from data bit 0. A control read returns the enable in bit 0, the status in the top bit, and 0 in every bit between them.
- R3: A read of offset 0x104 returns the low word and a read of offset 0x105 returns the high word. Every read produces exactly one `rd_valid` pulse, in the cycle after its request edge.
- R4: While enabled, the two-word count rises by one every cycle and carries from the low word into the high word. It wraps to 0 only at 2^(2*WORD_W), which is 2^64 at the default width.
- R5: A high-word read that immediately follows a low-word read, with no event and no carry in between, sets the status bit to 1.
- R6: A high-word read that is not immediately preceded by a low-word read sets the status bit to 0.
- R7: An `evt_taken` pulse in any cycle from the low-word read through the high-word read, both included, makes that high-word read set the status bit to 0.
- R8: Any other access between the low read and the high read breaks the pair. A new low-word read starts a fresh pair.
- R9: If the count carries into the high word after the low read was sampled, and before the high read's own edge, that high read sets the status bit to 0.
- R10: Writes to the low-word or high-word offsets do not change the count.
- R11: A read of any unmapped offset returns 0.
- R12: Control reads do not change the status bit. The status bit changes only on low-word and high-word reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_en | input | 1 | Register access request this cycle |
| acc_wr | input | 1 | 1 for a write, 0 for a read |
| acc_addr | input | ADDR_W | Register offset |
| acc_wdata | input | WORD_W | Write data |
| evt_taken | input | 1 | One-cycle pulse: the core took an interrupt or exception |
| rd_valid | output | 1 | Read response valid, one cycle after the request |
| rd_data | output | WORD_W | Read response data |

## Verification
The assertions assume that `evt_taken` is a one-cycle pulse synchronous to `clk`. They also assume that `acc_addr`, `acc_wr` and `acc_wdata` are meaningful whenever `acc_en` is high, and that responses are never stalled. The stimulus holds to this: it changes inputs only on the falling edge, issues at most one access per cycle, and pulses the event for a single cycle. The stimulus places events, carries and foreign accesses at each position of a low/high pair, including the cycle of the low read and the cycle of the high read. It uses a narrow word so that carries and the full wrap are reached.

// File: rtl/tick_pkg.sv
package tick_pkg;

  // Classification of one register access
  typedef enum logic [2:0] {
    ACC_IDLE,
    ACC_CTRL_RD,
    ACC_CTRL_WR,
    ACC_LO_RD,
    ACC_HI_RD,
    ACC_DATA_WR,
    ACC_MISC_RD,
    ACC_MISC_WR
  } acc_kind_e;

  localparam int unsigned DEF_CTRL_OFF = 'h103;
  localparam int unsigned DEF_LO_OFF   = 'h104;
  localparam int unsigned DEF_HI_OFF   = 'h105;

  function automatic logic kind_is_read(acc_kind_e k);
    return (k == ACC_CTRL_RD) || (k == ACC_LO_RD) ||
           (k == ACC_HI_RD)   || (k == ACC_MISC_RD);
  endfunction

endpackage

// File: rtl/tick_decode.sv
module tick_decode
  import tick_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned CTRL_OFF = DEF_CTRL_OFF,
  parameter int unsigned LO_OFF   = DEF_LO_OFF,
  parameter int unsigned HI_OFF   = DEF_HI_OFF
) (
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  output acc_kind_e         kind_o
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFF);
  localparam logic [ADDR_W-1:0] LO_A   = ADDR_W'(LO_OFF);
  localparam logic [ADDR_W-1:0] HI_A   = ADDR_W'(HI_OFF);

  logic hit_ctrl, hit_lo, hit_hi;

  assign hit_ctrl = (acc_addr == CTRL_A);
  assign hit_lo   = (acc_addr == LO_A);
  assign hit_hi   = (acc_addr == HI_A);

  always_comb begin
    kind_o = ACC_IDLE;
    if (acc_en) begin
      if (acc_wr) begin
        if (hit_ctrl)              kind_o = ACC_CTRL_WR;
        else if (hit_lo || hit_hi) kind_o = ACC_DATA_WR;
        else                       kind_o = ACC_MISC_WR;
      end else begin
        if (hit_ctrl)    kind_o = ACC_CTRL_RD;
        else if (hit_lo) kind_o = ACC_LO_RD;
        else if (hit_hi) kind_o = ACC_HI_RD;
        else             kind_o = ACC_MISC_RD;
      end
    end
  end

endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned SEGS   = 2,
  localparam int unsigned CNT_W = WORD_W * SEGS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_wr,
  input  logic             en_val,
  output logic             en_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             lo_carry_o
);
  logic              en_q;
  logic [WORD_W-1:0] seg_q [SEGS];
  logic [SEGS:0]     cin;

  always_ff @(posedge clk) begin
    if (rst)        en_q <= 1'b0;
    else if (en_wr) en_q <= en_val;
  end

  assign cin[0] = en_q;

  // One word-wide segment per step of the ripple carry chain
  generate
    for (genvar g = 0; g < SEGS; g++) begin : g_seg
      assign cin[g+1] = cin[g] & (&seg_q[g]);
      assign cnt_o[g*WORD_W +: WORD_W] = seg_q[g];

      always_ff @(posedge clk) begin
        if (rst)         seg_q[g] <= '0;
        else if (cin[g]) seg_q[g] <= seg_q[g] + 1'b1;
      end
    end
  endgenerate

  assign en_o       = en_q;
  assign lo_carry_o = cin[1];

  // R4: a carry out of the low word leaves that word at zero
  p_carry_zeroes_low_r4: assert property (@(posedge clk) disable iff (rst)
    lo_carry_o |=> (cnt_o[WORD_W-1:0] == '0));

  // R2: with counting disabled the count holds
  p_hold_when_off_r2: assert property (@(posedge clk) disable iff (rst)
    (!en_o && !en_wr) |=> $stable(cnt_o));

endmodule

// File: rtl/tick_tracker.sv
module tick_tracker
  import tick_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  acc_kind_e kind_i,
  input  logic      evt_i,
  input  logic      carry_i,
  output logic      status_o
);
  logic armed_q;    // a low read has been sampled and no other access has followed
  logic spoiled_q;  // an event or a carry has occurred since that low read
  logic status_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q   <= 1'b0;
      spoiled_q <= 1'b0;
      status_q  <= 1'b0;
    end else begin
      unique case (kind_i)
        ACC_LO_RD: begin
          armed_q   <= 1'b1;
          spoiled_q <= evt_i | carry_i;
          status_q  <= 1'b0;
        end
        ACC_HI_RD: begin
          // a carry on the high read's own edge is harmless: the old high word is returned
          status_q  <= armed_q & ~spoiled_q & ~evt_i;
          armed_q   <= 1'b0;
          spoiled_q <= 1'b0;
        end
        ACC_IDLE: begin
          spoiled_q <= spoiled_q | evt_i | carry_i;
        end
        default: begin
          armed_q   <= 1'b0;
          spoiled_q <= 1'b0;
        end
      endcase
    end
  end

  assign status_o = status_q;

  // R5: the status can only rise on a high-word read
  p_rise_on_high_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(status_o) |-> $past(kind_i == ACC_HI_RD));

  // R6: a high read with no pair open reports failure
  p_unpaired_high_r6: assert property (@(posedge clk) disable iff (rst)
    (kind_i == ACC_HI_RD && !armed_q) |=> !status_o);

  // R7: an event on the high read's cycle reports failure
  p_event_spoils_r7: assert property (@(posedge clk) disable iff (rst)
    (kind_i == ACC_HI_RD && evt_i) |=> !status_o);

  // R8: a control access closes any open pair
  p_foreign_closes_r8: assert property (@(posedge clk) disable iff (rst)
    (kind_i == ACC_CTRL_RD || kind_i == ACC_CTRL_WR) |=> !armed_q);

  // R12: a control read leaves the status unchanged
  p_ctrl_keeps_status_r12: assert property (@(posedge clk) disable iff (rst)
    (kind_i == ACC_CTRL_RD) |=> $stable(status_o));

endmodule

// File: rtl/split_counter.sv
module split_counter
  import tick_pkg::*;
#(
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned CTRL_OFF = DEF_CTRL_OFF,
  parameter int unsigned LO_OFF   = DEF_LO_OFF,
  parameter int unsigned HI_OFF   = DEF_HI_OFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [WORD_W-1:0] acc_wdata,
  input  logic              evt_taken,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data
);
  localparam int unsigned SEGS  = 2;
  localparam int unsigned CNT_W = SEGS * WORD_W;

  acc_kind_e        kind;
  logic             en;
  logic [CNT_W-1:0] cnt;
  logic             lo_carry;
  logic             status;
  logic             unused_wdata;

  assign unused_wdata = ^acc_wdata[WORD_W-1:1];

  tick_decode #(
    .ADDR_W  (ADDR_W),
    .CTRL_OFF(CTRL_OFF),
    .LO_OFF  (LO_OFF),
    .HI_OFF  (HI_OFF)
  ) u_decode (
    .acc_en  (acc_en),
    .acc_wr  (acc_wr),
    .acc_addr(acc_addr),
    .kind_o  (kind)
  );

  tick_counter #(
    .WORD_W(WORD_W),
    .SEGS  (SEGS)
  ) u_counter (
    .clk       (clk),
    .rst       (rst),
    .en_wr     (kind == ACC_CTRL_WR),
    .en_val    (acc_wdata[0]),
    .en_o      (en),
    .cnt_o     (cnt),
    .lo_carry_o(lo_carry)
  );

  tick_tracker u_tracker (
    .clk     (clk),
    .rst     (rst),
    .kind_i  (kind),
    .evt_i   (evt_taken),
    .carry_i (lo_carry),
    .status_o(status)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= kind_is_read(kind);
      unique case (kind)
        ACC_CTRL_RD: rd_data <= {status, {(WORD_W-2){1'b0}}, en};
        ACC_LO_RD:   rd_data <= cnt[WORD_W-1:0];
        ACC_HI_RD:   rd_data <= cnt[CNT_W-1 -: WORD_W];
        default:     rd_data <= '0;
      endcase
    end
  end

  // R3: every response follows a read request by one cycle
  p_rsp_after_read_r3: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(acc_en && !acc_wr));

  // R2: the bits between enable and status read as zero
  p_ctrl_gap_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(kind == ACC_CTRL_RD)) |-> (rd_data[WORD_W-2:1] == '0));

  // R11: unmapped reads return zero
  p_misc_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(kind == ACC_MISC_RD)) |-> (rd_data == '0));

  // R10: a write to a data word causes no jump in the count
  p_data_wr_no_jump_r10: assert property (@(posedge clk) disable iff (rst)
    (kind == ACC_DATA_WR && !en) |=> $stable(cnt));

endmodule

// File: tb/test_split_counter.sv
module test_split_counter;
  localparam int W = 8;
  localparam int A = 12;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         a_en = 1'b0, a_wr = 1'b0, evt = 1'b0;
  logic [A-1:0] a_addr = '0;
  logic [W-1:0] a_wdata = '0;
  logic         rd_valid;
  logic [W-1:0] rd_data;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  split_counter #(.WORD_W(W), .ADDR_W(A)) i_split_counter (
    .clk(clk), .rst(rst), .acc_en(a_en), .acc_wr(a_wr), .acc_addr(a_addr),
    .acc_wdata(a_wdata), .evt_taken(evt), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // Reference model built from the requirements
  logic [2*W-1:0] m_cnt = '0;
  logic           m_en = 1'b0, m_arm = 1'b0, m_spoil = 1'b0, m_stat = 1'b0;
  string          cur_tag = "R1";
  logic [W-1:0]   exp_q[$];
  string          tag_q[$];

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = '0; m_en = 0; m_arm = 0; m_spoil = 0; m_stat = 0;
    end else begin
      logic carry;
      carry = m_en && (m_cnt[W-1:0] == '1);
      if (a_en && !a_wr) begin
        logic [W-1:0] e;
        if (a_addr == 12'h103)      e = {m_stat, {(W-2){1'b0}}, m_en};
        else if (a_addr == 12'h104) e = m_cnt[W-1:0];
        else if (a_addr == 12'h105) e = m_cnt[2*W-1:W];
        else                        e = '0;
        exp_q.push_back(e);
        tag_q.push_back(cur_tag);
      end
      if (a_en && !a_wr && a_addr == 12'h104) begin
        m_arm = 1; m_spoil = evt | carry; m_stat = 0;
      end else if (a_en && !a_wr && a_addr == 12'h105) begin
        m_stat = m_arm & ~m_spoil & ~evt; m_arm = 0; m_spoil = 0;
      end else if (!a_en) begin
        m_spoil = m_spoil | evt | carry;
      end else begin
        m_arm = 0; m_spoil = 0;
      end
      if (m_en) m_cnt = m_cnt + 1'b1;
      if (a_en && a_wr && a_addr == 12'h103) m_en = a_wdata[0];
    end
  end

  // Monitor: compare each response with the scoreboard head
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R3: unexpected response, actual %h expected none", rd_data);
      end else begin
        logic [W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", t, rd_data, e);
        end
      end
    end
  end

  task automatic access(input bit wr, input logic [A-1:0] addr,
                        input logic [W-1:0] wd, input string tag, input bit ev = 0);
    cur_tag = tag;
    a_en = 1'b1; a_wr = wr; a_addr = addr; a_wdata = wd; evt = ev;
    @(negedge clk);
  endtask

  task automatic idle(input int n, input bit ev = 0);
    a_en = 1'b0; a_wr = 1'b0; evt = ev;
    @(negedge clk);
    evt = 1'b0;
    for (int i = 1; i < n; i++) @(negedge clk);
  endtask

  task automatic rd(input logic [A-1:0] addr, input string tag, input bit ev = 0);
    access(1'b0, addr, '0, tag, ev);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rd_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1: rd_valid actual %b expected 0", rd_valid);
    end
    rst = 1'b0;
    @(negedge clk);
    // R1 reset values
    rd(12'h103, "R1"); rd(12'h104, "R1"); rd(12'h105, "R1"); idle(2);
    // R2 enable and readback
    access(1'b1, 12'h103, 8'h01, "R2"); idle(3);
    rd(12'h103, "R2");
    // R5 coherent pair, R12 status persists over control reads
    rd(12'h104, "R5"); rd(12'h105, "R5"); rd(12'h103, "R5"); rd(12'h103, "R12");
    // R6 high read without a low read
    rd(12'h105, "R6"); rd(12'h103, "R6");
    // R7 event between, on the high read, and on the low read
    rd(12'h104, "R7"); idle(1, 1'b1); rd(12'h105, "R7"); rd(12'h103, "R7");
    rd(12'h104, "R7"); rd(12'h105, "R7", 1'b1); rd(12'h103, "R7");
    rd(12'h104, "R7", 1'b1); rd(12'h105, "R7"); rd(12'h103, "R7");
    // R8 foreign access breaks the pair, a second low read re-arms
    rd(12'h104, "R8"); rd(12'h103, "R8"); rd(12'h105, "R8"); rd(12'h103, "R8");
    rd(12'h104, "R8"); rd(12'h104, "R8"); rd(12'h105, "R8"); rd(12'h103, "R8");
    idle(1);
    // R9 carry after low read spoils the pair
    while (m_cnt[W-1:0] != 8'hFE) @(negedge clk);
    rd(12'h104, "R9"); idle(1); rd(12'h105, "R9"); rd(12'h103, "R9"); idle(1);
    // R9 pair just short of a carry stays coherent
    while (m_cnt[W-1:0] != 8'hFC) @(negedge clk);
    rd(12'h104, "R9"); rd(12'h105, "R9"); rd(12'h103, "R9"); idle(1);
    // R4 full wrap of the two-word count
    while (m_cnt != 16'hFFFE) @(negedge clk);
    rd(12'h104, "R4"); rd(12'h105, "R4"); rd(12'h103, "R4");
    rd(12'h104, "R4"); rd(12'h105, "R4"); idle(1);
    // R2 disable holds the count
    access(1'b1, 12'h103, 8'h00, "R2"); idle(4);
    rd(12'h104, "R2"); idle(3); rd(12'h104, "R2"); rd(12'h103, "R2");
    // R10 writes to data words are ignored
    access(1'b1, 12'h104, 8'h5A, "R10"); access(1'b1, 12'h105, 8'hA5, "R10"); idle(1);
    rd(12'h104, "R10"); rd(12'h105, "R10");
    // R11 unmapped reads
    rd(12'h000, "R11"); rd(12'h106, "R11"); rd(12'hFFF, "R11");
    idle(4);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R3: missing responses actual %0d expected 0", exp_q.size());
    end
    finish_run();
  end

endmodule